// File: doc/BRIEF.md
# SPI Slave Command Frame Decoder

This block sits behind an SPI byte shifter on the slave side of a register and DMA access link. Each received byte arrives as a one-cycle `rx_valid` pulse while chip select is low. The first byte of a frame is an opcode. The opcode fixes how many address, size and data bytes follow. An optional CRC7 trailer byte can close the frame. Once the frame is complete, the block issues a single strobe, either to a simple internal register port or to a DMA engine. It then queues a response for the host to clock out.

`tx_byte` holds the byte that the shifter sends in the next byte slot, and it advances on every received byte while a response is pending. Every response starts with the echoed opcode and a status byte. A successful single or internal read continues with filler bytes, a header byte whose upper nibble is 0xF, the 4-byte register word and, where enabled, a CRC16 over that word. The register file, the bulk data phase and the shifter itself are outside this block.

Top module: `spi_cmd_decoder`

## Requirements
- R1: Frame length is set by the opcode. The bytes counted after the opcode are: 0xC1 and 0xC2 take 5, 0xC7 and 0xC8 take 6, 0xC3 takes 6, 0xC4 and 0xCA take 3, 0xC9 takes 7, and 0xC5, 0xC6 and 0xCF take 0. One more byte follows when `crc7_en` is high. `tx_byte` reads 0x00 until the frame is complete and shows the echoed opcode right after the last frame byte.
- R2: Single write 0xC9 carries a 24-bit address, most significant byte first, then a 32-bit word, most significant byte first. Single read 0xCA carries a 24-bit address. These appear on `cmd_addr`/`reg_wdata` together with a `reg_wr` or `reg_rd` pulse, with `reg_internal` low.
- R3: Internal write 0xC3 carries 2 address bytes and a big-endian word. Internal read 0xC4 carries 2 address bytes and an ignored pad byte. Bit 7 of the first address byte drives `reg_clockless`. `cmd_addr` is the remaining 15 bits, zero-extended, and `reg_internal` is high.
- R4: The response is the opcode followed by a status byte. For a successful read, `FILL_BYTES` bytes of 0x00 follow, then header 0xF3, then `reg_rdata` least significant byte first. `reg_rdata` is sampled in the cycle `reg_rd` is high. After the last response byte `tx_byte` returns to 0x00.
- R5: A read response carries two more bytes, high byte first, when `crc16_en` is high and the access is not clockless. They hold a CRC16 (polynomial 0x1021, initial 0xFFFF, MSB first) computed over the four data bytes in transmit order.
- R6: DMA opcodes pulse `dma_start` with a 24-bit big-endian `cmd_addr` and a `dma_size`. The size is 2 bytes for 0xC1/0xC2 and 3 bytes for 0xC7/0xC8, most significant first. `dma_write` is high for 0xC1 and 0xC7.
- R7: With `crc7_en` high, the trailer must equal {crc,0}. Here crc is the CRC7 (x^7+x^3+1, initial 0x7F, MSB first) of all preceding frame bytes. On a mismatch the status is 0x02 and no strobe is issued.
- R8: An unknown opcode is answered immediately after that single byte with the echoed opcode and status 0x01. No strobe is issued.
- R9: Opcodes 0xC5, 0xC6 and 0xCF form complete frames on their own (plus the trailer if enabled). They return status 0x00 and issue no strobe.
- R10: Raising `cs_n` at any point discards the frame or response in progress. The next byte after chip select returns low is then parsed as an opcode.
- R11: After reset, `tx_byte` is 0x00 and all strobes are low.
- R12: At most one of `reg_wr`, `reg_rd`, `dma_start` is high in a cycle. Each is a one-cycle pulse in the cycle after the final frame byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rx_valid | input | 1 | One-cycle pulse per received byte |
| rx_byte | input | 8 | Received byte |
| crc7_en | input | 1 | Expect a CRC7 trailer on each frame |
| crc16_en | input | 1 | Append CRC16 to non-clockless read data |
| reg_rdata | input | 32 | Register read data, valid while reg_rd is high |
| tx_byte | output | 8 | Byte to send in the next slot |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_internal | output | 1 | Access targets the internal register space |
| reg_clockless | output | 1 | Internal access flagged as clockless |
| cmd_addr | output | 24 | Decoded address |
| reg_wdata | output | 32 | Decoded write word |
| dma_start | output | 1 | DMA command strobe |
| dma_write | output | 1 | DMA direction, 1 for write |
| dma_size | output | 24 | Decoded DMA length |

## Verification
The bench focuses on frame-length accounting. A decoder that counts one byte too few answers early and leaves `tx_byte` nonzero in the middle of the frame. One that counts one byte too many misaligns every field. Corrupted CRC7 trailers and unknown opcodes check that the strobes stay silent and that the status byte shows the right code. A decoder that checked the trailer loosely would write registers from corrupted frames. Clockless internal reads with CRC16 enabled catch a design that appends the CRC16 anyway, which would shift the host's framing. A frame cut off by chip select shows whether leftover parser state leaks into the next command.

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder #(
  parameter int FILL_BYTES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        crc7_en,
  input  logic        crc16_en,
  input  logic [31:0] reg_rdata,
  output logic [7:0]  tx_byte,
  output logic        reg_wr,
  output logic        reg_rd,
  output logic        reg_internal,
  output logic        reg_clockless,
  output logic [23:0] cmd_addr,
  output logic [31:0] reg_wdata,
  output logic        dma_start,
  output logic        dma_write,
  output logic [23:0] dma_size
);

  localparam logic [7:0] OP_DMA_WR  = 8'hC1;
  localparam logic [7:0] OP_DMA_RD  = 8'hC2;
  localparam logic [7:0] OP_INT_WR  = 8'hC3;
  localparam logic [7:0] OP_INT_RD  = 8'hC4;
  localparam logic [7:0] OP_TERM    = 8'hC5;
  localparam logic [7:0] OP_REPEAT  = 8'hC6;
  localparam logic [7:0] OP_XDMA_WR = 8'hC7;
  localparam logic [7:0] OP_XDMA_RD = 8'hC8;
  localparam logic [7:0] OP_SGL_WR  = 8'hC9;
  localparam logic [7:0] OP_SGL_RD  = 8'hCA;
  localparam logic [7:0] OP_RESET   = 8'hCF;

  localparam logic [7:0] ST_OK    = 8'h00;
  localparam logic [7:0] ST_BADOP = 8'h01;
  localparam logic [7:0] ST_CRC   = 8'h02;

  localparam int HDR_POS  = 2 + FILL_BYTES;
  localparam int LEN_RD   = HDR_POS + 5;
  localparam int IW       = $clog2(LEN_RD + 3);
  localparam logic [IW-1:0] I_HDR   = IW'(HDR_POS);
  localparam logic [IW-1:0] I_CRCH  = IW'(HDR_POS + 5);
  localparam logic [IW-1:0] L_SHORT = IW'(2);
  localparam logic [IW-1:0] L_RD    = IW'(LEN_RD);
  localparam logic [IW-1:0] L_RDCRC = IW'(LEN_RD + 2);

  typedef enum logic [1:0] {S_OP, S_FIELD, S_CRC, S_RSP} state_t;

  state_t          state;
  logic [7:0]      op_q, status_q;
  logic [2:0]      left;
  logic [55:0]     sh;
  logic [6:0]      crc_q;
  logic [IW-1:0]   idx, rsp_len;
  logic [31:0]     rdata_q;

  function automatic logic [3:0] frame_len(input logic [7:0] op);
    case (op)
      OP_DMA_WR, OP_DMA_RD:             frame_len = 4'd5;
      OP_XDMA_WR, OP_XDMA_RD, OP_INT_WR: frame_len = 4'd6;
      OP_INT_RD, OP_SGL_RD:             frame_len = 4'd3;
      OP_SGL_WR:                        frame_len = 4'd7;
      OP_TERM, OP_REPEAT, OP_RESET:     frame_len = 4'd0;
      default:                          frame_len = 4'hF;
    endcase
  endfunction

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic [7:0] b);
    logic [6:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[6] ^ b[i]) r = {r[5:0], 1'b0} ^ 7'h09;
      else             r = {r[5:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [15:0] crc16_word(input logic [31:0] d);
    logic [15:0] r;
    r = 16'hFFFF;
    for (int k = 0; k < 4; k++)
      for (int i = 7; i >= 0; i--) begin
        if (r[15] ^ d[8*k+i]) r = {r[14:0], 1'b0} ^ 16'h1021;
        else                  r = {r[14:0], 1'b0};
      end
    return r;
  endfunction

  logic        byte_in, frame_end, crc_bad, ok, is_rd, cl_nx;
  logic [3:0]  flen_op;
  logic [7:0]  op_nx;
  logic [55:0] sh_nx;
  logic [15:0] crc16_v;

  assign byte_in = rx_valid & ~cs_n;
  assign flen_op = frame_len(rx_byte);
  assign op_nx   = (state == S_OP) ? rx_byte : op_q;
  assign sh_nx   = (state == S_FIELD) ? {sh[47:0], rx_byte} : sh;
  assign crc_bad = (state == S_CRC) && (rx_byte != {crc_q, 1'b0});
  assign frame_end = byte_in && (((state == S_OP) && (flen_op == 4'd0) && !crc7_en) ||
                                 ((state == S_FIELD) && (left == 3'd1) && !crc7_en) ||
                                 (state == S_CRC));
  assign ok    = frame_end && !crc_bad;
  assign is_rd = (op_nx == OP_INT_RD) || (op_nx == OP_SGL_RD);
  assign cl_nx = (op_nx == OP_INT_RD) ? sh_nx[23] : 1'b0;
  assign crc16_v = crc16_word(rdata_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OP; op_q <= '0; status_q <= '0; left <= '0; sh <= '0; crc_q <= '0;
      idx <= '0; rsp_len <= '0; rdata_q <= '0;
      reg_wr <= 1'b0; reg_rd <= 1'b0; dma_start <= 1'b0; dma_write <= 1'b0;
      reg_internal <= 1'b0; reg_clockless <= 1'b0;
      cmd_addr <= '0; reg_wdata <= '0; dma_size <= '0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      dma_start <= 1'b0;
      if (reg_rd) rdata_q <= reg_rdata;
      if (cs_n) begin
        state <= S_OP;
        idx <= '0;
      end else if (rx_valid) begin
        case (state)
          S_OP: begin
            op_q  <= rx_byte;
            sh    <= '0;
            crc_q <= crc7_step(7'h7F, rx_byte);
            left  <= flen_op[2:0];
            if (flen_op == 4'hF) begin
              status_q <= ST_BADOP;
              rsp_len  <= L_SHORT;
              idx      <= '0;
              state    <= S_RSP;
            end else if (flen_op != 4'd0) begin
              state <= S_FIELD;
            end else if (crc7_en) begin
              state <= S_CRC;
            end
          end
          S_FIELD: begin
            sh    <= sh_nx;
            crc_q <= crc7_step(crc_q, rx_byte);
            left  <= left - 3'd1;
            if (left == 3'd1 && crc7_en) state <= S_CRC;
          end
          S_CRC: ;
          S_RSP: begin
            if (idx == rsp_len - 1'b1) begin
              state <= S_OP;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          default: state <= S_OP;
        endcase
        if (frame_end) begin
          state    <= S_RSP;
          idx      <= '0;
          status_q <= crc_bad ? ST_CRC : ST_OK;
          rsp_len  <= L_SHORT;
          if (ok) begin
            if (is_rd) rsp_len <= (crc16_en && !cl_nx) ? L_RDCRC : L_RD;
            case (op_nx)
              OP_SGL_WR: begin
                reg_wr <= 1'b1; reg_internal <= 1'b0; reg_clockless <= 1'b0;
                cmd_addr <= sh_nx[55:32]; reg_wdata <= sh_nx[31:0];
              end
              OP_SGL_RD: begin
                reg_rd <= 1'b1; reg_internal <= 1'b0; reg_clockless <= 1'b0;
                cmd_addr <= sh_nx[23:0];
              end
              OP_INT_WR: begin
                reg_wr <= 1'b1; reg_internal <= 1'b1; reg_clockless <= sh_nx[47];
                cmd_addr <= {9'd0, sh_nx[46:32]}; reg_wdata <= sh_nx[31:0];
              end
              OP_INT_RD: begin
                reg_rd <= 1'b1; reg_internal <= 1'b1; reg_clockless <= sh_nx[23];
                cmd_addr <= {9'd0, sh_nx[22:8]};
              end
              OP_DMA_WR, OP_DMA_RD: begin
                dma_start <= 1'b1; dma_write <= (op_nx == OP_DMA_WR);
                cmd_addr <= sh_nx[39:16]; dma_size <= {8'd0, sh_nx[15:0]};
              end
              OP_XDMA_WR, OP_XDMA_RD: begin
                dma_start <= 1'b1; dma_write <= (op_nx == OP_XDMA_WR);
                cmd_addr <= sh_nx[47:24]; dma_size <= sh_nx[23:0];
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  always_comb begin
    tx_byte = 8'h00;
    if (state == S_RSP) begin
      if (idx == '0)            tx_byte = op_q;
      else if (idx == IW'(1))   tx_byte = status_q;
      else if (idx < I_HDR)     tx_byte = 8'h00;
      else if (idx == I_HDR)    tx_byte = 8'hF3;
      else if (idx < I_CRCH) begin
        case (2'(idx - I_HDR - 1'b1))
          2'd0:    tx_byte = rdata_q[7:0];
          2'd1:    tx_byte = rdata_q[15:8];
          2'd2:    tx_byte = rdata_q[23:16];
          default: tx_byte = rdata_q[31:24];
        endcase
      end
      else if (idx == I_CRCH)   tx_byte = crc16_v[15:8];
      else                      tx_byte = crc16_v[7:0];
    end
  end

  p_strobe_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, reg_rd, dma_start}));

  p_strobe_after_byte_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd || dma_start) |-> $past(rx_valid && !cs_n));

  p_strobe_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd || dma_start) |=> !(reg_wr || reg_rd || dma_start));

  p_cs_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (tx_byte == 8'h00));

  p_crc_bad_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_in && crc_bad) |=> (!reg_wr && !reg_rd && !dma_start && tx_byte == op_q));

  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !cs_n) |=> $stable(tx_byte));

endmodule

// File: tb/test_spi_cmd_decoder.sv
module test_spi_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int FILL = 2;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rx_valid = 1'b0, crc7_en = 1'b0, crc16_en = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [31:0] reg_rdata = '0;
  logic [7:0] tx_byte;
  logic reg_wr, reg_rd, reg_internal, reg_clockless, dma_start, dma_write;
  logic [23:0] cmd_addr, dma_size;
  logic [31:0] reg_wdata;

  spi_cmd_decoder #(.FILL_BYTES(FILL)) i_spi_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .crc7_en(crc7_en), .crc16_en(crc16_en), .reg_rdata(reg_rdata), .tx_byte(tx_byte),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_internal(reg_internal), .reg_clockless(reg_clockless),
    .cmd_addr(cmd_addr), .reg_wdata(reg_wdata), .dma_start(dma_start), .dma_write(dma_write),
    .dma_size(dma_size));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  int n_wr = 0, n_rd = 0, n_dma = 0, n_multi = 0;
  logic [23:0] c_addr, c_size;
  logic [31:0] c_wdata;
  logic c_int, c_cl, c_dw;
  logic [7:0] fb [0:15];
  int fl;

  always @(negedge clk) begin
    if (int'(reg_wr) + int'(reg_rd) + int'(dma_start) > 1) n_multi++;
    if (reg_wr)    n_wr++;
    if (reg_rd)    n_rd++;
    if (dma_start) n_dma++;
    if (reg_wr || reg_rd || dma_start) begin
      c_addr = cmd_addr; c_size = dma_size; c_wdata = reg_wdata;
      c_int = reg_internal; c_cl = reg_clockless; c_dw = dma_write;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] m_crc7(input logic [6:0] c, input logic [7:0] b);
    logic [6:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fbk = r[6] ^ b[i];
      r = {r[5:0], 1'b0};
      if (fbk) r[3] = ~r[3];
      if (fbk) r[0] = ~r[0];
    end
    return r;
  endfunction

  function automatic logic [15:0] m_crc16(input logic [31:0] d);
    logic [15:0] r = 16'hFFFF;
    for (int k = 0; k < 4; k++)
      for (int i = 7; i >= 0; i--) begin
        logic fbk = r[15] ^ d[8*k+i];
        r = {r[14:0], 1'b0};
        if (fbk) r = r ^ 16'h1021;
      end
    return r;
  endfunction

  function automatic int m_len(input logic [7:0] op);
    case (op)
      8'hC1, 8'hC2: return 5;
      8'hC3, 8'hC7, 8'hC8: return 6;
      8'hC4, 8'hCA: return 3;
      8'hC9: return 7;
      8'hC5, 8'hC6, 8'hCF: return 0;
      default: return -1;
    endcase
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [23:0] addr, input logic [31:0] data,
                         input logic [23:0] size, input bit use_crc, input bit corrupt);
    int n, rlen;
    logic [6:0] c;
    logic [7:0] rsp [0:15];
    bit rd, cl, good;
    logic [15:0] cc;
    n = m_len(op);
    crc7_en = use_crc;
    reg_rdata = $urandom;
    fb[0] = op; fl = 1;
    case (op)
      8'hC1, 8'hC2: begin fb[1]=addr[23:16]; fb[2]=addr[15:8]; fb[3]=addr[7:0]; fb[4]=size[15:8]; fb[5]=size[7:0]; end
      8'hC7, 8'hC8: begin fb[1]=addr[23:16]; fb[2]=addr[15:8]; fb[3]=addr[7:0]; fb[4]=size[23:16]; fb[5]=size[15:8]; fb[6]=size[7:0]; end
      8'hC3: begin fb[1]=addr[15:8]; fb[2]=addr[7:0]; fb[3]=data[31:24]; fb[4]=data[23:16]; fb[5]=data[15:8]; fb[6]=data[7:0]; end
      8'hC4: begin fb[1]=addr[15:8]; fb[2]=addr[7:0]; fb[3]=8'h00; end
      8'hC9: begin fb[1]=addr[23:16]; fb[2]=addr[15:8]; fb[3]=addr[7:0]; fb[4]=data[31:24]; fb[5]=data[23:16]; fb[6]=data[15:8]; fb[7]=data[7:0]; end
      8'hCA: begin fb[1]=addr[23:16]; fb[2]=addr[15:8]; fb[3]=addr[7:0]; end
      default: ;
    endcase
    if (n > 0) fl = 1 + n;
    good = (n >= 0) && !(use_crc && corrupt);
    if (use_crc && n >= 0) begin
      c = 7'h7F;
      for (int i = 0; i < fl; i++) c = m_crc7(c, fb[i]);
      fb[fl] = {c, 1'b0} ^ (corrupt ? 8'h02 : 8'h00);
      fl++;
    end
    n_wr = 0; n_rd = 0; n_dma = 0; n_multi = 0;
    for (int i = 0; i < fl; i++) begin
      chk("R1 silent during frame", {24'd0, tx_byte}, 32'h0);
      send(fb[i]);
    end
    rd = good && (op == 8'hC4 || op == 8'hCA);
    cl = (op == 8'hC4) && addr[15];
    rsp[0] = op;
    rsp[1] = (n < 0) ? 8'h01 : (good ? 8'h00 : 8'h02);
    rlen = 2;
    if (rd) begin
      for (int i = 0; i < FILL; i++) rsp[2+i] = 8'h00;
      rsp[2+FILL] = 8'hF3;
      for (int i = 0; i < 4; i++) rsp[3+FILL+i] = reg_rdata[8*i +: 8];
      rlen = 7 + FILL;
      if (crc16_en && !cl) begin
        cc = m_crc16(reg_rdata);
        rsp[rlen] = cc[15:8]; rsp[rlen+1] = cc[7:0];
        rlen += 2;
      end
    end
    for (int i = 0; i < rlen; i++) begin
      chk(i == 0 ? "R1 opcode echo" : (i == 1 ? (n < 0 ? "R8 status" : "R7 status") :
          (i >= 7 + FILL ? "R5 crc16 byte" : "R4 read byte")), {24'd0, tx_byte}, {24'd0, rsp[i]});
      send(8'hFF);
    end
    chk("R4 idle after response", {24'd0, tx_byte}, 32'h0);
    chk("R12 one strobe per cycle", n_multi, 0);
    chk("R7 R8 R9 strobe count", n_wr + n_rd + n_dma,
        (good && (op != 8'hC5 && op != 8'hC6 && op != 8'hCF)) ? 1 : 0);
    if (good) begin
      case (op)
        8'hC9: begin chk("R2 wr", n_wr, 1); chk("R2 addr", c_addr, addr); chk("R2 data", c_wdata, data); chk("R2 ext", c_int, 0); end
        8'hCA: begin chk("R2 rd", n_rd, 1); chk("R2 addr", c_addr, addr); chk("R2 ext", c_int, 0); end
        8'hC3: begin chk("R3 wr", n_wr, 1); chk("R3 addr", c_addr, {9'd0, addr[14:0]}); chk("R3 data", c_wdata, data);
                     chk("R3 int", c_int, 1); chk("R3 clockless", c_cl, addr[15]); end
        8'hC4: begin chk("R3 rd", n_rd, 1); chk("R3 addr", c_addr, {9'd0, addr[14:0]});
                     chk("R3 int", c_int, 1); chk("R3 clockless", c_cl, addr[15]); end
        8'hC1, 8'hC2: begin chk("R6 dma", n_dma, 1); chk("R6 addr", c_addr, addr);
                     chk("R6 size", c_size, {8'd0, size[15:0]}); chk("R6 dir", c_dw, op == 8'hC1); end
        8'hC7, 8'hC8: begin chk("R6 dma", n_dma, 1); chk("R6 addr", c_addr, addr);
                     chk("R6 size", c_size, size); chk("R6 dir", c_dw, op == 8'hC7); end
        default: ;
      endcase
    end
  endtask

  bit done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [0:12];
    ops = '{8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6, 8'hC7, 8'hC8, 8'hC9, 8'hCA, 8'hCF, 8'hC0, 8'h3A};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R11 reset tx", {24'd0, tx_byte}, 32'h0);
    chk("R11 reset strobes", {29'd0, reg_wr, reg_rd, dma_start}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); cs_n = 1'b0;

    run_cmd(8'hC9, 24'h123456, 32'hDEADBEEF, 0, 0, 0);
    run_cmd(8'hCA, 24'hABCDEF, 0, 0, 1, 0);
    crc16_en = 1'b1;
    run_cmd(8'hCA, 24'h000010, 0, 0, 0, 0);
    run_cmd(8'hC4, 24'h0080A4, 0, 0, 1, 0);
    run_cmd(8'hC4, 24'h0024A4, 0, 0, 1, 0);
    run_cmd(8'hC3, 24'h00FFFF, 32'h01020304, 0, 1, 0);
    run_cmd(8'hC7, 24'hFFFFFF, 0, 24'hFEDCBA, 1, 0);
    run_cmd(8'hC2, 24'h000000, 0, 24'h00FFFF, 0, 0);
    run_cmd(8'hC9, 24'h111111, 32'h22222222, 0, 1, 1);
    run_cmd(8'hC5, 0, 0, 0, 1, 0);
    run_cmd(8'hCF, 0, 0, 0, 0, 0);
    run_cmd(8'h00, 0, 0, 0, 1, 0);

    n_wr = 0;
    crc7_en = 1'b0;
    send(8'hC9); send(8'h01); send(8'h02);
    @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 cs abort tx", {24'd0, tx_byte}, 32'h0);
    cs_n = 1'b0;
    run_cmd(8'hCA, 24'h0A0B0C, 0, 0, 0, 0);
    chk("R10 no write from aborted frame", n_wr, 0);

    for (int it = 0; it < 60; it++) begin
      logic [7:0] op;
      op = ops[$urandom % 13];
      crc16_en = $urandom % 2;
      run_cmd(op, 24'($urandom), $urandom, 24'($urandom), $urandom % 2, ($urandom % 6) == 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule